// File: doc/BRIEF.md
# Dual-Port Semaphore Token Bank

This block holds a small bank of hardware ownership tokens that two independent ports, called left and right, share. Software on either side claims a token before it touches a shared resource and gives the token back afterwards. No shared variable or lock sequence in memory is needed, because the bank resolves every conflict in hardware.

A port picks a token with the low address bits while its semaphore select is low. To request the token it writes a word whose bit 0 is 0. To give the token back, or to withdraw a request that is still waiting, it writes a word whose bit 0 is 1. The port then reads the token. The read word is all zeros when this port owns the token and all ones when it does not.

A request that finds the token held by the other port is kept as pending. When the owner releases the token, a pending request from the other side takes ownership at once. If both ports request a free token in the same cycle, the left port wins. Within one cycle the left port's write is applied first and the right port's write second. An access that asserts semaphore select together with chip enable and a byte lane select is illegal. Such an access is dropped and reported on that port's error output.

Top module: `sem_flags`

## Requirements
- R1: After reset no token is owned and no request is pending. Every token reads as all ones on both ports, and both error outputs are 0.
- R2: When a port requests a token that the other port does not own, the requester becomes the owner. From the next cycle on, a read of that token by the owner returns 0 on all DATA_W bits.
- R3: A write takes its value from bit 0 of the write data only. Bit 0 = 0 requests and bit 0 = 1 releases, whatever the other bits hold.
- R4: The token is selected by address bits [IDX_W-1:0] (bits 2:0 with eight tokens). Higher address bits are ignored, and the tokens are independent of each other.
- R5: A request for a token the other port owns leaves ownership unchanged. The requester keeps reading all ones and the owner keeps reading all zeros.
- R6: When the owner releases a token while the other port has a request pending, the other port becomes the owner from the next cycle.
- R7: A release by the owner with nothing pending frees the token. A release by a port that only has a request pending cancels that request, so that a later release by the owner leaves the token free.
- R8: When both ports request the same free token in the same cycle, the left port becomes the owner and the right request stays pending. If both ports write the same token in one cycle, the left write is applied first.
- R9: Read data is driven only while semaphore select is low, read/write is high and output enable is low. Otherwise the port's read data is all zeros.
- R10: A write takes effect when semaphore select is low and read/write is low, with chip enable and both lane selects inactive. A write with semaphore select high changes nothing.
- R11: An access with semaphore select low, chip enable low and either lane select low is illegal. It changes no token and returns all-zero read data. The port's error output is 1 in the cycle that follows each illegal cycle and 0 after a legal or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sem_l_ni | input | 1 | Left semaphore select, active low |
| ce_l_ni | input | 1 | Left chip enable, active low |
| rw_l_i | input | 1 | Left read (1) / write (0) |
| oe_l_ni | input | 1 | Left output enable, active low |
| ub_l_ni | input | 1 | Left upper lane select, active low |
| lb_l_ni | input | 1 | Left lower lane select, active low |
| addr_l_i | input | ADDR_W | Left address; low IDX_W bits pick the token |
| wdata_l_i | input | DATA_W | Left write data; bit 0 used |
| rdata_l_o | output | DATA_W | Left token status, replicated |
| err_l_o | output | 1 | Left illegal-access flag |
| sem_r_ni | input | 1 | Right semaphore select, active low |
| ce_r_ni | input | 1 | Right chip enable, active low |
| rw_r_i | input | 1 | Right read (1) / write (0) |
| oe_r_ni | input | 1 | Right output enable, active low |
| ub_r_ni | input | 1 | Right upper lane select, active low |
| lb_r_ni | input | 1 | Right lower lane select, active low |
| addr_r_i | input | ADDR_W | Right address; low IDX_W bits pick the token |
| wdata_r_i | input | DATA_W | Right write data; bit 0 used |
| rdata_r_o | output | DATA_W | Right token status, replicated |
| err_r_o | output | 1 | Right illegal-access flag |

## Verification
A corrupted owner or pending bit shows up on the next read of that token. One port sees zeros where it expects ones, or the other way round, or both ports read zeros at once. A lost pending bit only shows up when the owner releases the token: the waiting port should own it one cycle later and does not. For that reason the stimulus always releases a token after a request has been left waiting on it and reads the token in the following cycle. A fault in the illegal-access detection shows up one cycle after the access, either as a wrong error bit or as a token that has changed.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  typedef struct packed {
    logic rd;   // legal read in progress
    logic bad;  // illegal select combination
  } port_cmd_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned ADDR_W    = 14,
  localparam int unsigned IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 sem_ni,
  input  logic                 ce_ni,
  input  logic                 rw_i,
  input  logic                 oe_ni,
  input  logic                 ub_ni,
  input  logic                 lb_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wbit_i,
  output sem_pkg::port_cmd_t   cmd_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [NUM_FLAGS-1:0] req_o,
  output logic [NUM_FLAGS-1:0] rel_o
);
  logic sel, bad, wr;
  logic unused_addr;

  assign sel = ~sem_ni;
  assign bad = sel & ~ce_ni & (~ub_ni | ~lb_ni);
  assign wr  = sel & ~rw_i & ~bad;

  assign idx_o       = addr_i[IDX_W-1:0];
  assign unused_addr = ^addr_i[ADDR_W-1:IDX_W];

  assign cmd_o.rd  = sel & rw_i & ~oe_ni & ~bad;
  assign cmd_o.bad = bad;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_sel
    logic hit;
    assign hit      = wr && (idx_o == IDX_W'(g));
    assign req_o[g] = hit & ~wbit_i;
    assign rel_o[g] = hit &  wbit_i;
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l_req_i,
  input  logic l_rel_i,
  input  logic r_req_i,
  input  logic r_rel_i,
  output logic l_own_o,
  output logic r_own_o
);
  import sem_pkg::*;

  owner_e owner_q, owner_d;
  logic   pend_l_q, pend_l_d;
  logic   pend_r_q, pend_r_d;

  // Left write resolved first, right write sees its result.
  always_comb begin
    owner_d  = owner_q;
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;

    if (l_req_i) begin
      if (owner_d == OWN_RIGHT) pend_l_d = 1'b1;
      else begin
        owner_d  = OWN_LEFT;
        pend_l_d = 1'b0;
      end
    end else if (l_rel_i) begin
      if (owner_d == OWN_LEFT) begin
        if (pend_r_d) begin
          owner_d  = OWN_RIGHT;
          pend_r_d = 1'b0;
        end else begin
          owner_d  = OWN_NONE;
        end
      end
      pend_l_d = 1'b0;
    end

    if (r_req_i) begin
      if (owner_d == OWN_LEFT) pend_r_d = 1'b1;
      else begin
        owner_d  = OWN_RIGHT;
        pend_r_d = 1'b0;
      end
    end else if (r_rel_i) begin
      if (owner_d == OWN_RIGHT) begin
        if (pend_l_d) begin
          owner_d  = OWN_LEFT;
          pend_l_d = 1'b0;
        end else begin
          owner_d  = OWN_NONE;
        end
      end
      pend_r_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign l_own_o = (owner_q == OWN_LEFT);
  assign r_own_o = (owner_q == OWN_RIGHT);
endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic [NUM_FLAGS-1:0] own_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 rd_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic status;
  // 0 = held by this port, 1 = not held
  assign status  = ~own_i[idx_i];
  assign rdata_o = rd_i ? {DATA_W{status}} : '0;
endmodule

// File: rtl/sem_flags.sv
module sem_flags #(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 14,
  localparam int unsigned IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sem_l_ni,
  input  logic              ce_l_ni,
  input  logic              rw_l_i,
  input  logic              oe_l_ni,
  input  logic              ub_l_ni,
  input  logic              lb_l_ni,
  input  logic [ADDR_W-1:0] addr_l_i,
  input  logic [DATA_W-1:0] wdata_l_i,
  output logic [DATA_W-1:0] rdata_l_o,
  output logic              err_l_o,
  input  logic              sem_r_ni,
  input  logic              ce_r_ni,
  input  logic              rw_r_i,
  input  logic              oe_r_ni,
  input  logic              ub_r_ni,
  input  logic              lb_r_ni,
  input  logic [ADDR_W-1:0] addr_r_i,
  input  logic [DATA_W-1:0] wdata_r_i,
  output logic [DATA_W-1:0] rdata_r_o,
  output logic              err_r_o
);
  import sem_pkg::*;

  port_cmd_t            cmd_l, cmd_r;
  logic [IDX_W-1:0]     idx_l, idx_r;
  logic [NUM_FLAGS-1:0] req_l, rel_l, req_r, rel_r;
  logic [NUM_FLAGS-1:0] own_l, own_r;
  logic                 unused_wdata;

  assign unused_wdata = ^{wdata_l_i[DATA_W-1:1], wdata_r_i[DATA_W-1:1]};

  sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_l (
    .sem_ni(sem_l_ni), .ce_ni(ce_l_ni), .rw_i(rw_l_i), .oe_ni(oe_l_ni),
    .ub_ni(ub_l_ni), .lb_ni(lb_l_ni), .addr_i(addr_l_i), .wbit_i(wdata_l_i[0]),
    .cmd_o(cmd_l), .idx_o(idx_l), .req_o(req_l), .rel_o(rel_l)
  );

  sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_r (
    .sem_ni(sem_r_ni), .ce_ni(ce_r_ni), .rw_i(rw_r_i), .oe_ni(oe_r_ni),
    .ub_ni(ub_r_ni), .lb_ni(lb_r_ni), .addr_i(addr_r_i), .wbit_i(wdata_r_i[0]),
    .cmd_o(cmd_r), .idx_o(idx_r), .req_o(req_r), .rel_o(rel_r)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .l_req_i(req_l[g]),
      .l_rel_i(rel_l[g]),
      .r_req_i(req_r[g]),
      .r_rel_i(rel_r[g]),
      .l_own_o(own_l[g]),
      .r_own_o(own_r[g])
    );
  end

  sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
    .own_i(own_l), .idx_i(idx_l), .rd_i(cmd_l.rd), .rdata_o(rdata_l_o)
  );

  sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
    .own_i(own_r), .idx_i(idx_r), .rd_i(cmd_r.rd), .rdata_o(rdata_r_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_l_o <= 1'b0;
      err_r_o <= 1'b0;
    end else begin
      err_l_o <= cmd_l.bad;
      err_r_o <= cmd_r.bad;
    end
  end
endmodule

// File: rtl/sem_flags_chk.sv
module sem_flags_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sem_l_ni, ce_l_ni, rw_l_i, oe_l_ni, ub_l_ni, lb_l_ni,
  input logic [ADDR_W-1:0] addr_l_i,
  input logic [DATA_W-1:0] rdata_l_o,
  input logic              err_l_o,
  input logic              sem_r_ni, ce_r_ni, rw_r_i, oe_r_ni, ub_r_ni, lb_r_ni,
  input logic [ADDR_W-1:0] addr_r_i,
  input logic [DATA_W-1:0] rdata_r_o,
  input logic              err_r_o
);
  logic bad_l, bad_r, rd_l, rd_r;
  assign bad_l = !sem_l_ni && !ce_l_ni && (!ub_l_ni || !lb_l_ni);
  assign bad_r = !sem_r_ni && !ce_r_ni && (!ub_r_ni || !lb_r_ni);
  assign rd_l  = !sem_l_ni && rw_l_i && !oe_l_ni;
  assign rd_r  = !sem_r_ni && rw_r_i && !oe_r_ni;

  assert_err_l_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_l |=> err_l_o);
  assert_err_l_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_l |=> !err_l_o);
  assert_err_r_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_r |=> err_r_o);
  assert_err_r_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_r |=> !err_r_o);
  assert_idle_l_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_l || bad_l) |-> rdata_l_o == '0);
  assert_idle_r_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_r || bad_r) |-> rdata_r_o == '0);
  assert_repl_l_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_l_o == '0) || (rdata_l_o == '1));
  assert_repl_r_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_r_o == '0) || (rdata_r_o == '1));
  assert_mutex_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_l && rd_r && !bad_l && !bad_r &&
     addr_l_i[IDX_W-1:0] == addr_r_i[IDX_W-1:0])
    |-> !(rdata_l_o == '0 && rdata_r_o == '0));
endmodule

bind sem_flags sem_flags_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .sem_l_ni(sem_l_ni), .ce_l_ni(ce_l_ni), .rw_l_i(rw_l_i), .oe_l_ni(oe_l_ni),
  .ub_l_ni(ub_l_ni), .lb_l_ni(lb_l_ni), .addr_l_i(addr_l_i),
  .rdata_l_o(rdata_l_o), .err_l_o(err_l_o),
  .sem_r_ni(sem_r_ni), .ce_r_ni(ce_r_ni), .rw_r_i(rw_r_i), .oe_r_ni(oe_r_ni),
  .ub_r_ni(ub_r_ni), .lb_r_ni(lb_r_ni), .addr_r_i(addr_r_i),
  .rdata_r_o(rdata_r_o), .err_r_o(err_r_o)
);

// File: tb/tb_sem_flags.sv
module tb_sem_flags;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 14;
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] REQ_WORD = 16'hA5A4; // bit0 = 0 (R3)
  localparam logic [DATA_W-1:0] REL_WORD = 16'h5A5B; // bit0 = 1 (R3)

  // row: [19:16] req tag, [15:14] left op, [13:11] left idx, [10:9] right op,
  // [8:6] right idx, [5:3] read idx, [1] left expect, [0] right expect
  // op: 0 none, 1 request, 2 release
  localparam int unsigned NROWS = 16;
  localparam logic [19:0] TBL [NROWS] = '{
    {4'd2, 2'd1, 3'd0, 2'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1}, // R2
    {4'd5, 2'd0, 3'd0, 2'd1, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1}, // R5
    {4'd6, 2'd2, 3'd0, 2'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0}, // R6
    {4'd7, 2'd0, 3'd0, 2'd2, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1}, // R7
    {4'd8, 2'd1, 3'd3, 2'd1, 3'd3, 3'd3, 1'b0, 1'b0, 1'b1}, // R8
    {4'd6, 2'd2, 3'd3, 2'd0, 3'd0, 3'd3, 1'b0, 1'b1, 1'b0}, // R6
    {4'd8, 2'd1, 3'd3, 2'd2, 3'd3, 3'd3, 1'b0, 1'b0, 1'b1}, // R8 same-cycle hand-over
    {4'd5, 2'd0, 3'd0, 2'd1, 3'd3, 3'd3, 1'b0, 1'b0, 1'b1}, // R5
    {4'd7, 2'd0, 3'd0, 2'd2, 3'd3, 3'd3, 1'b0, 1'b0, 1'b1}, // R7 cancel
    {4'd7, 2'd2, 3'd3, 2'd0, 3'd0, 3'd3, 1'b0, 1'b1, 1'b1}, // R7 free
    {4'd4, 2'd1, 3'd5, 2'd1, 3'd6, 3'd5, 1'b0, 1'b0, 1'b1}, // R4
    {4'd4, 2'd0, 3'd0, 2'd0, 3'd0, 3'd6, 1'b0, 1'b1, 1'b0}, // R4
    {4'd4, 2'd2, 3'd5, 2'd2, 3'd6, 3'd5, 1'b0, 1'b1, 1'b1}, // R4
    {4'd4, 2'd0, 3'd0, 2'd0, 3'd0, 3'd6, 1'b0, 1'b1, 1'b1}, // R4
    {4'd8, 2'd1, 3'd7, 2'd1, 3'd7, 3'd7, 1'b0, 1'b0, 1'b1}, // R8
    {4'd8, 2'd2, 3'd7, 2'd2, 3'd7, 3'd7, 1'b0, 1'b1, 1'b1}  // R8
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sem_l, ce_l, rw_l, oe_l, ub_l, lb_l, sem_r, ce_r, rw_r, oe_r, ub_r, lb_r;
  logic [ADDR_W-1:0] addr_l, addr_r;
  logic [DATA_W-1:0] wd_l, wd_r, rd_l, rd_r;
  logic err_l, err_r;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_flags #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sem_l_ni(sem_l), .ce_l_ni(ce_l), .rw_l_i(rw_l), .oe_l_ni(oe_l),
    .ub_l_ni(ub_l), .lb_l_ni(lb_l), .addr_l_i(addr_l), .wdata_l_i(wd_l),
    .rdata_l_o(rd_l), .err_l_o(err_l),
    .sem_r_ni(sem_r), .ce_r_ni(ce_r), .rw_r_i(rw_r), .oe_r_ni(oe_r),
    .ub_r_ni(ub_r), .lb_r_ni(lb_r), .addr_r_i(addr_r), .wdata_r_i(wd_r),
    .rdata_r_o(rd_r), .err_r_o(err_r)
  );

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {sem_l, ce_l, rw_l, oe_l, ub_l, lb_l} = 6'b111111;
    {sem_r, ce_r, rw_r, oe_r, ub_r, lb_r} = 6'b111111;
    addr_l = '0; addr_r = '0; wd_l = '0; wd_r = '0;
  endtask

  task automatic wr_l(logic [1:0] op, logic [ADDR_W-1:0] a);
    if (op != 2'd0) begin
      sem_l = 1'b0; rw_l = 1'b0; addr_l = a;
      wd_l = (op == 2'd1) ? REQ_WORD : REL_WORD;
    end
  endtask

  task automatic wr_r(logic [1:0] op, logic [ADDR_W-1:0] a);
    if (op != 2'd0) begin
      sem_r = 1'b0; rw_r = 1'b0; addr_r = a;
      wd_r = (op == 2'd1) ? REQ_WORD : REL_WORD;
    end
  endtask

  // both ports read token a; values checked before next edge
  task automatic rd_both(logic [ADDR_W-1:0] a);
    idle();
    sem_l = 1'b0; oe_l = 1'b0; addr_l = a;
    sem_r = 1'b0; oe_r = 1'b0; addr_r = a;
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 err_l", {15'd0, err_l}, '0);
    chk("R1 err_r", {15'd0, err_r}, '0);
    for (int i = 0; i < 8; i++) begin
      rd_both(ADDR_W'(i));
      chk($sformatf("R1 left token %0d", i), rd_l, ONES);
      chk($sformatf("R1 right token %0d", i), rd_r, ONES);
      @(negedge clk);
    end

    // table walk: one write cycle, one read cycle
    for (int i = 0; i < NROWS; i++) begin
      idle();
      wr_l(TBL[i][15:14], ADDR_W'(TBL[i][13:11]));
      wr_r(TBL[i][10:9],  ADDR_W'(TBL[i][8:6]));
      @(negedge clk);
      rd_both(ADDR_W'(TBL[i][5:3]));
      chk($sformatf("R%0d row %0d left", TBL[i][19:16], i), rd_l, {DATA_W{TBL[i][1]}});
      chk($sformatf("R%0d row %0d right", TBL[i][19:16], i), rd_r, {DATA_W{TBL[i][0]}});
      @(negedge clk);
    end

    // R4 R10: high address bits ignored, chip enable low with lanes off is legal
    idle();
    wr_l(2'd1, 14'h3FF9);
    ce_l = 1'b0; wd_l = 16'hFFFE;
    @(negedge clk);
    rd_both(14'h0001);
    chk("R4 left owns token 1", rd_l, '0);
    chk("R4 right sees token 1 held", rd_r, ONES);
    chk("R10 no error on legal write", {15'd0, err_l}, '0);
    @(negedge clk);

    // R10: write with select high does nothing
    idle();
    rw_l = 1'b0; addr_l = 14'h0001; wd_l = REL_WORD;
    @(negedge clk);
    rd_both(14'h0001);
    chk("R10 deselected release ignored", rd_l, '0);
    @(negedge clk);

    // R9: read qualifiers
    idle();
    sem_r = 1'b0; oe_r = 1'b1; addr_r = 14'h0001; #1;
    chk("R9 oe high gives zero", rd_r, '0);
    sem_r = 1'b1; oe_r = 1'b0; #1;
    chk("R9 select high gives zero", rd_r, '0);
    sem_r = 1'b0; #1;
    chk("R9 proper read", rd_r, ONES);
    @(negedge clk);

    // R11: illegal left release of token 1
    idle();
    wr_l(2'd2, 14'h0001);
    ce_l = 1'b0; lb_l = 1'b0;
    @(posedge clk); #1;
    chk("R11 err_l raised", {15'd0, err_l}, 16'd1);
    chk("R11 err_r quiet", {15'd0, err_r}, '0);
    @(negedge clk);
    idle();
    @(posedge clk); #1;
    chk("R11 err_l cleared", {15'd0, err_l}, '0);
    @(negedge clk);
    rd_both(14'h0001);
    chk("R11 illegal release ignored", rd_l, '0);
    @(negedge clk);

    // R11: illegal right request on token 2, then illegal read
    idle();
    wr_r(2'd1, 14'h0002);
    ce_r = 1'b0; ub_r = 1'b0;
    @(posedge clk); #1;
    chk("R11 err_r raised", {15'd0, err_r}, 16'd1);
    @(negedge clk);
    rd_both(14'h0002);
    chk("R11 illegal request ignored right", rd_r, ONES);
    chk("R11 illegal request ignored left", rd_l, ONES);
    ce_r = 1'b0; ub_r = 1'b0; #1;
    chk("R11 illegal read returns zero", rd_r, '0);
    @(negedge clk);

    // R1: reset in mid-run frees held token 1
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_both(14'h0001);
    chk("R1 token freed by reset", rd_l, ONES);
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule